// File: doc/BRIEF.md
# Manchester Load-Modulation Reply Transmitter

This block produces the tag-to-reader reply of a low-frequency tag emulator by switching a coil-load control line. It watches a strobe that marks every rising edge of the reader field and counts whole carrier periods since the most recent one. When a reply is requested, the coil stays unloaded until the programmed response delay, less a fixed gap allowance of 8 carrier periods, has passed since that edge. It then sends a frame.

A frame is five one-bits as a start marker, followed by the payload bits. Each bit is Manchester coded over 31 carrier periods, with the loaded and unloaded halves swapped according to the bit value. A carrier period is a programmable number of system clocks. The bit timer restarts at every bit boundary. A one-cycle done pulse marks the end of the frame. The payload buffer, bit length, carrier period and delay are supplied by the surrounding logic. Carrier period and delay are expected to stay constant while the block is busy.

Top module: `lf_reply_tx`

## Requirements
- R1: While idle or waiting to transmit, `coil_load` is 0. `busy` is 1 from the cycle after a `start` accepted in idle until the cycle in which `done` is 1.
- R2: Let C be `carrier_clks` and thr be `resp_delay`−8, or 0 when `resp_delay` ≤ 8. With the latest `reader_rise` sampled at clock edge E, transmission starts at edge S = E + thr·C + 1. A `reader_rise` seen while waiting restarts this count.
- R3: If the delay has already elapsed when `start` is sampled at edge T, transmission starts at edge T+1. In general S = max(T+1, E+thr·C+1).
- R4: Every frame begins with five 1 bits before any payload bit.
- R5: Within a bit, carrier periods 0–14 carry the bit value and periods 15–30 carry its inverse on `coil_load` (1 = loaded). A 1 bit is therefore loaded then unloaded, and a 0 bit is unloaded then loaded.
- R6: Every bit lasts exactly 31 carrier periods, and bit n of the frame starts at edge S + 31·n·C.
- R7: Payload bits are sent MSB-first starting at `payload[MAX_BITS-1]`, and `bit_len` of them are sent. A `bit_len` above MAX_BITS is clamped to MAX_BITS, and a `bit_len` of 0 sends the start marker only.
- R8: At the edge that ends the last bit, `done` becomes 1 for one cycle, `busy` becomes 0 and `coil_load` becomes 0.
- R9: A `start` while `busy` is 1 is ignored: the frame contents and its timing are unchanged.
- R10: After reset, `coil_load`, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reader_rise | input | 1 | One-cycle strobe marking a rising edge of the reader field |
| start | input | 1 | Request to send a reply, sampled in idle only |
| payload | input | MAX_BITS | Reply bits, latched at start, first bit at the top index |
| bit_len | input | LEN_W | Number of payload bits |
| carrier_clks | input | CLK_W | System clocks per carrier period |
| resp_delay | input | DLY_W | Response delay in carrier periods, measured from the last reader rising edge |
| coil_load | output | 1 | 1 = coil shorted (loaded), 0 = open |
| busy | output | 1 | Reply pending or in progress |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
The bench measures the reply start against the reader edge for several delays and carrier periods. This exposes a design that forgets the 8-period allowance or starts one period late. It also covers a delay below the allowance and a start that arrives after the delay has already expired, either of which would stall or underflow a naive comparison. A second reader edge during the wait must push the start later, and a design that keeps the first edge would reply early. Each bit is sampled on both sides of its half boundary and at the bit boundary, which shows a drifting timer, a swapped Manchester polarity or a missing start marker. The long-length, zero-length and start-while-busy cases catch a wrong clamp, a bit counter that is off by one and a payload that is reloaded mid-frame.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_SEND = 2'd2
   } lfr_state_t;

   localparam int unsigned SOF_BITS  = 5;
   localparam int unsigned GAP_ALLOW = 8;
   localparam int unsigned HALF_PER  = 15;
   localparam int unsigned BIT_PER   = 31;
endpackage

// File: rtl/lfr_tick_gen.sv
module lfr_tick_gen #(
   parameter int unsigned CLK_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CLK_W-1:0] period,
   output logic             tick
);
   logic [CLK_W-1:0] pcnt;

   // a period of 0 behaves as 1
   assign tick = ({1'b0, pcnt} + 1'b1) >= {1'b0, period};

   always_ff @(posedge clk) begin
      if (!rst_n || clr || tick) pcnt <= '0;
      else                       pcnt <= pcnt + 1'b1;
   end
endmodule

// File: rtl/lfr_gap_timer.sv
module lfr_gap_timer #(
   parameter int unsigned CLK_W = 8,
   parameter int unsigned DLY_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reader_rise,
   input  logic [CLK_W-1:0] carrier_clks,
   input  logic [DLY_W-1:0] resp_delay,
   output logic             reached
);
   import lfr_pkg::*;

   localparam logic [DLY_W-1:0] GAP = DLY_W'(GAP_ALLOW);

   logic             tick;
   logic [DLY_W-1:0] ecnt;
   logic [DLY_W-1:0] thr;

   lfr_tick_gen #(.CLK_W(CLK_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (reader_rise),
      .period (carrier_clks),
      .tick   (tick)
   );

   assign thr     = (resp_delay > GAP) ? resp_delay - GAP : '0;
   assign reached = ecnt >= thr;

   always_ff @(posedge clk) begin
      if (!rst_n || reader_rise)  ecnt <= '0;
      else if (tick && ~&ecnt)    ecnt <= ecnt + 1'b1;
   end
endmodule

// File: rtl/lfr_bit_seq.sv
module lfr_bit_seq #(
   parameter int unsigned MAX_BITS = 80,
   parameter int unsigned LEN_W    = 7,
   parameter int unsigned IDX_W    = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                run,
   input  logic                tick,
   input  logic [MAX_BITS-1:0] payload,
   input  logic [LEN_W-1:0]    bit_len,
   output logic                cur_bit,
   output logic                first_half,
   output logic                frame_end,
   output logic [IDX_W-1:0]    frame_bits
);
   import lfr_pkg::*;

   localparam int unsigned TMR_W = $clog2(BIT_PER);
   localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(BIT_PER - 1);
   localparam logic [TMR_W-1:0] TMR_HALF = TMR_W'(HALF_PER);
   localparam logic [IDX_W-1:0] SOF_N    = IDX_W'(SOF_BITS);

   logic [MAX_BITS-1:0] sh;
   logic [TMR_W-1:0]    bit_tmr;
   logic [IDX_W-1:0]    bidx;
   logic [LEN_W-1:0]    len_c;
   logic                bit_end;

   assign len_c      = (bit_len > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : bit_len;
   assign cur_bit    = (bidx < SOF_N) ? 1'b1 : sh[MAX_BITS-1];
   assign first_half = bit_tmr < TMR_HALF;
   assign bit_end    = run && tick && (bit_tmr == TMR_LAST);
   assign frame_end  = bit_end && (bidx == frame_bits - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh         <= '0;
         bit_tmr    <= '0;
         bidx       <= '0;
         frame_bits <= '0;
      end else if (load) begin
         sh         <= payload;
         bit_tmr    <= '0;
         bidx       <= '0;
         frame_bits <= IDX_W'(len_c) + SOF_N;
      end else if (bit_end) begin
         bit_tmr <= '0;
         bidx    <= bidx + 1'b1;
         if (bidx >= SOF_N) sh <= sh << 1;
      end else if (run && tick) begin
         bit_tmr <= bit_tmr + 1'b1;
      end
   end
endmodule

// File: rtl/lf_reply_tx.sv
module lf_reply_tx #(
   parameter int unsigned MAX_BITS = 80,
   parameter int unsigned CLK_W    = 8,
   parameter int unsigned DLY_W    = 10,
   localparam int unsigned LEN_W   = $clog2(MAX_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reader_rise,
   input  logic                start,
   input  logic [MAX_BITS-1:0] payload,
   input  logic [LEN_W-1:0]    bit_len,
   input  logic [CLK_W-1:0]    carrier_clks,
   input  logic [DLY_W-1:0]    resp_delay,
   output logic                coil_load,
   output logic                busy,
   output logic                done
);
   import lfr_pkg::*;

   localparam int unsigned IDX_W = $clog2(MAX_BITS + SOF_BITS + 1);

   generate
      if (MAX_BITS < 1)         begin : g_bad_len  $error("MAX_BITS must be at least 1");  end
      if (CLK_W < 1)            begin : g_bad_clk  $error("CLK_W must be at least 1");     end
      if (DLY_W < 4)            begin : g_bad_dly  $error("DLY_W too narrow for the gap"); end
   endgenerate

   lfr_state_t          state;
   logic                reached;
   logic                bit_tick;
   logic                cur_bit;
   logic                first_half;
   logic                frame_end;
   logic [IDX_W-1:0]    frame_bits;
   logic                sending;

   assign sending = (state == ST_SEND);

   lfr_gap_timer #(.CLK_W(CLK_W), .DLY_W(DLY_W)) u_gap (
      .clk          (clk),
      .rst_n        (rst_n),
      .reader_rise  (reader_rise),
      .carrier_clks (carrier_clks),
      .resp_delay   (resp_delay),
      .reached      (reached)
   );

   lfr_tick_gen #(.CLK_W(CLK_W)) u_btick (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!sending),
      .period (carrier_clks),
      .tick   (bit_tick)
   );

   lfr_bit_seq #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       ((state == ST_IDLE) && start),
      .run        (sending),
      .tick       (bit_tick),
      .payload    (payload),
      .bit_len    (bit_len),
      .cur_bit    (cur_bit),
      .first_half (first_half),
      .frame_end  (frame_end),
      .frame_bits (frame_bits)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         done <= frame_end;
         unique case (state)
            ST_IDLE: if (start)     state <= ST_WAIT;
            ST_WAIT: if (reached)   state <= ST_SEND;
            ST_SEND: if (frame_end) state <= ST_IDLE;
            default:                state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign coil_load = sending && (first_half ? cur_bit : !cur_bit);
endmodule

// File: rtl/lf_reply_tx_chk.sv
module lf_reply_tx_chk #(
   parameter int unsigned IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       state,
   input  logic             first_half,
   input  logic [IDX_W-1:0] frame_bits,
   input  logic             coil_load,
   input  logic             busy,
   input  logic             done
);
   AST_REST_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state != 2'd2) |-> !coil_load);                                    // R1
   AST_BUSY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !coil_load);                                        // R1
   AST_HALF_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd2) && ($past(state) == 2'd2) && $fell(first_half)
         |-> (coil_load != $past(coil_load)));                            // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                    // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !coil_load && $past(busy)));                     // R8
   AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(frame_bits));                     // R9
endmodule

bind lf_reply_tx lf_reply_tx_chk #(.IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .state      (state),
   .first_half (first_half),
   .frame_bits (frame_bits),
   .coil_load  (coil_load),
   .busy       (busy),
   .done       (done)
);

// File: tb/lf_reply_tx_tb.sv
module lf_reply_tx_tb;
   localparam int MB = 80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reader_rise = 1'b0;
   logic          start = 1'b0;
   logic [MB-1:0] payload = '0;
   logic [6:0]    bit_len = '0;
   logic [7:0]    carrier_clks = 8'd4;
   logic [9:0]    resp_delay = 10'd208;
   logic          coil_load, busy, done;

   int errors = 0;
   int checks = 0;
   int edge_no = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) edge_no <= edge_no + 1;

   lf_reply_tx u_dut (
      .clk(clk), .rst_n(rst_n), .reader_rise(reader_rise), .start(start),
      .payload(payload), .bit_len(bit_len), .carrier_clks(carrier_clks),
      .resp_delay(resp_delay), .coil_load(coil_load), .busy(busy), .done(done)
   );

   // pattern16, len7, cpc8, dly10, gap8
   localparam int NV = 5;
   localparam logic [48:0] VEC [NV] = '{
      {16'hA5C3, 7'd16, 8'd4, 10'd208, 8'd3},
      {16'h3C00, 7'd8,  8'd3, 10'd204, 8'd0},
      {16'hFFFF, 7'd16, 8'd2, 10'd212, 8'd5},
      {16'h0000, 7'd12, 8'd5, 10'd20,  8'd1},
      {16'h8000, 7'd1,  8'd1, 10'd5,   8'd2}
   };

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at edge %0d", req, act, exp, edge_no);
      end
   endtask

   task automatic wait_to(int k);
      while (edge_no < k) @(negedge clk);
   endtask

   task automatic pulse_rise(output int e);
      reader_rise = 1'b1;
      @(negedge clk);
      reader_rise = 1'b0;
      e = edge_no;
   endtask

   task automatic run_frame(logic [MB-1:0] pl, int len, int cpc, int dly, int gap,
                            bit extra_rise, bit poke_start);
      int e, t, thr, s, nb, lc;
      carrier_clks = 8'(cpc);
      resp_delay   = 10'(dly);
      @(negedge clk);
      pulse_rise(e);
      repeat (gap) @(negedge clk);
      payload = pl;
      bit_len = 7'(len);
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      t = edge_no;
      check("R1 busy after start", busy, 1);
      check("R1 open while waiting", coil_load, 0);
      if (extra_rise) pulse_rise(e);
      thr = (dly > 8) ? dly - 8 : 0;
      s = e + thr * cpc + 1;
      if (t + 1 > s) s = t + 1;
      lc = (len > MB) ? MB : len;
      nb = 5 + lc;
      if (edge_no < s - 1) begin
         wait_to(s - 1);
         check("R2 still open before start", coil_load, 0);
         check("R1 busy while waiting", busy, 1);
      end
      for (int n = 0; n < nb; n++) begin
         int b, b0;
         b  = (n < 5) ? 1 : int'(pl[MB-1-(n-5)]);
         b0 = s + 31 * n * cpc;
         wait_to(b0);
         check((n < 5) ? "R4 marker bit first half" : "R7 payload bit first half", coil_load, b);
         wait_to(b0 + 15 * cpc - 1);
         check("R6 first half held to period 14", coil_load, b);
         wait_to(b0 + 15 * cpc);
         check("R5 second half inverted", coil_load, 1 - b);
         if (poke_start && n == 6) begin
            payload = ~pl;
            bit_len = 7'd3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
      end
      wait_to(s + 31 * nb * cpc - 1);
      check("R8 done low before end", done, 0);
      check("R8 busy before end", busy, 1);
      wait_to(s + 31 * nb * cpc);
      check("R8 done pulse", done, 1);
      check("R8 busy cleared", busy, 0);
      check("R8 coil open at end", coil_load, 0);
      wait_to(s + 31 * nb * cpc + 1);
      check("R8 done one cycle", done, 0);
      if (poke_start) check("R9 no restart after ignored start", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R10 coil after reset", coil_load, 0);
      check("R10 busy after reset", busy, 0);
      check("R10 done after reset", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 idle after release", busy, 0);

      for (int v = 0; v < NV; v++) begin
         logic [48:0] w;
         w = VEC[v];
         run_frame({w[48:33], 64'd0}, int'(w[32:26]), int'(w[25:18]),
                   int'(w[17:8]), int'(w[7:0]), 1'b0, 1'b0);
      end

      // R3: start arrives long after the delay expired
      run_frame({16'h6B00, 64'd0}, 8, 2, 12, 40, 1'b0, 1'b0);
      // R2: second reader edge while waiting pushes the start out
      run_frame({16'h9100, 64'd0}, 8, 2, 40, 0, 1'b1, 1'b0);
      // R7: length above capacity is clamped, full buffer sent
      run_frame({40'hF0F0_1234_AB, 40'h5_5AA3_C96E}, 100, 1, 10, 0, 1'b0, 1'b0);
      // R7: zero length sends only the marker
      run_frame({16'hFFFF, 64'd0}, 0, 2, 16, 0, 1'b0, 1'b0);
      // R9: start while busy is ignored
      run_frame({16'h5A00, 64'd0}, 8, 2, 208, 1, 1'b0, 1'b1);

      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (150000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
         end
      join_any
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule